// File: doc/BRIEF.md
# Decode-Stage Issue Interlock for a Multi-Latency Execute Stage

This block decides, one decoded instruction at a time, whether that instruction may leave decode this cycle or must wait. The execute stage behind it has five kinds of unit: an integer ALU, a load/store path, a pipelined floating-point adder, a pipelined multiplier and a divider that is not pipelined. Each unit needs a different number of cycles before its result can be forwarded. The decoder presents a valid flag, a unit code, a destination register and up to two source registers. The block answers combinationally with `stall` or `issue`.

Internally, the block keeps three kinds of record. Each register has a countdown to the cycle in which its pending result becomes forwardable. The divider has an occupancy counter. The floating-point write port has a reservation line that shows which future cycles already carry a writeback. A consumer of a pending value waits until the value can be forwarded. A second writer to a register that is still pending waits in decode. A divide waits while the divider is occupied. An instruction whose writeback would land on a cycle that is already reserved waits one cycle at a time until its slot is free. Independent instructions issue freely, so they can finish out of order.

Register addresses are `AW` bits wide. The top address bit selects the floating-point file. Address 0 is the integer zero register.

Top module: `hzu_issue_ctl`

## Requirements
- R1: With `dec_valid` low, both `stall` and `issue` are low. With `dec_valid` high, exactly one of them is high. Unit codes are: 0 integer ALU, 1 load/store, 2 FP add, 3 multiply, 4 divide. Codes 5 to 7 behave as the integer ALU.
- R2: Each unit has a forwarding latency in cycles: ALU 0, load/store 1, FP add 3, multiply 6, divide 24. A consumer that reads a producer's destination and is presented in the cycle right after the producer issues stalls exactly that many cycles.
- R3: A divide presented right after another divide stalls 24 cycles, even when the two divides share no register. Successive divides therefore issue at least 25 cycles apart.
- R4: An instruction whose destination still has a pending result stalls in decode until that result is forwardable. A second writer right after a multiply stalls 6 cycles.
- R5: Register address 0 is never marked pending. An ALU instruction that reads only register 0 and writes nothing always issues.
- R6: An issued instruction with an FP-file destination (top address bit 1) writes back `latency + 3` cycles after it issues. An instruction that would write back in a cycle already reserved stalls. Example: a multiply issued at cycle t and an FP add presented at t+3 produce exactly one stall.
- R7: A stalled instruction changes no tracking state. Withdrawing a divide that was stalling leaves its destination readable without delay.
- R8: An instruction independent of every pending result issues at once behind a long-latency producer, with no stall.
- R9: After reset no register is pending, the divider is free and no writeback is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_unit | input | 3 | Functional unit code of that instruction |
| dec_dst_en | input | 1 | The instruction writes a register |
| dec_dst | input | AW (6) | Destination register address |
| dec_src1_en | input | 1 | First source is used |
| dec_src1 | input | AW (6) | First source register address |
| dec_src2_en | input | 1 | Second source is used |
| dec_src2 | input | AW (6) | Second source register address |
| stall | output | 1 | Hold the instruction in decode this cycle |
| issue | output | 1 | The instruction leaves decode at the next edge |

## Verification
The bench builds the block with its default parameters: 64 registers, latencies of 1, 3, 6 and 24, a divider reissue interval of 25 and a writeback offset of 3. With these values a full divider window, the 27-cycle-deep writeback reservation line and the multiply-versus-add port collision all fall within a short directed sequence. Random traffic is confined to four integer and four floating-point registers. This makes RAW, WAW and port overlaps between the five unit types frequent and lets them interleave with a busy divider.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  typedef enum logic [2:0] {
    U_ALU  = 3'd0,
    U_LDST = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_FDIV = 3'd4
  } unit_e;

endpackage

// File: rtl/hzu_busy_table.sv
// Per-register countdown to the cycle a pending result becomes forwardable.
module hzu_busy_table #(
  parameter int NREG = 64,
  parameter int CW   = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_idx,
  input  logic [CW-1:0]   set_cnt,
  output logic [NREG-1:0] busy
);

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      if (r == 0) begin : g_zero
        assign busy[r] = 1'b0;
      end else begin : g_cnt
        logic [CW-1:0] cnt_q, cnt_d;
        logic          hit, cnt_en;

        always_comb begin
          hit    = set_en && (set_idx == AW'(r));
          cnt_en = hit || (cnt_q != '0);
          cnt_d  = cnt_q;
          if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
          if (hit)         cnt_d = set_cnt;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      cnt_q <= '0;
          else if (cnt_en) cnt_q <= cnt_d;
        end

        assign busy[r] = (cnt_q != '0);
      end
    end
  endgenerate

endmodule

// File: rtl/hzu_div_gate.sv
// Occupancy counter of the unpipelined divider.
module hzu_div_gate #(
  parameter int DIV_II = 25,
  localparam int CW = (DIV_II > 1) ? $clog2(DIV_II) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic free
);

  logic [CW-1:0] occ_q, occ_d;
  logic          occ_en;

  always_comb begin
    occ_en = start || (occ_q != '0);
    occ_d  = occ_q;
    if (occ_q != '0) occ_d = occ_q - CW'(1);
    if (start)       occ_d = CW'(DIV_II - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign free = (occ_q == '0);

endmodule

// File: rtl/hzu_wb_reserve.sv
// Shift line of booked write-port cycles; bit k = a writeback k cycles ahead.
module hzu_wb_reserve #(
  parameter int DEPTH = 28,
  localparam int RW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          book,
  input  logic [RW-1:0] slot,
  output logic          taken
);

  logic [DEPTH-1:0] res_q, res_d;

  assign taken = res_q[slot];

  always_comb begin
    res_d = res_q >> 1;
    if (book) res_d[slot - RW'(1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

endmodule

// File: rtl/hzu_issue_ctl.sv
// Decode-stage interlock: RAW, WAW, divider occupancy and write-port slot.
module hzu_issue_ctl #(
  parameter int NREG     = 64,
  parameter int LAT_ALU  = 0,
  parameter int LAT_LDST = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 24,
  parameter int DIV_II   = 25,
  parameter int WB_OFF   = 3,
  localparam int AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [2:0]    dec_unit,
  input  logic          dec_dst_en,
  input  logic [AW-1:0] dec_dst,
  input  logic          dec_src1_en,
  input  logic [AW-1:0] dec_src1,
  input  logic          dec_src2_en,
  input  logic [AW-1:0] dec_src2,
  output logic          stall,
  output logic          issue
);
  import hzu_pkg::*;

  localparam int MX1    = (LAT_FADD > LAT_LDST) ? LAT_FADD : LAT_LDST;
  localparam int MX2    = (LAT_FMUL > MX1) ? LAT_FMUL : MX1;
  localparam int MX3    = (LAT_ALU > MX2) ? LAT_ALU : MX2;
  localparam int MAXLAT = (LAT_FDIV > MX3) ? LAT_FDIV : MX3;
  localparam int CW     = $clog2(MAXLAT + 1);
  localparam int DEPTH  = MAXLAT + WB_OFF + 1;
  localparam int RW     = $clog2(DEPTH + 1);

  logic [NREG-1:0] busy;
  logic [CW-1:0]   lat;
  logic [RW-1:0]   wb_slot;
  logic            div_free, slot_taken;
  logic            raw_hit, waw_hit, div_hit, port_hit, hold;
  logic            fp_dst, is_div;
  logic            set_en, book, div_start;

  always_comb begin
    case (dec_unit)
      U_LDST:  lat = CW'(LAT_LDST);
      U_FADD:  lat = CW'(LAT_FADD);
      U_FMUL:  lat = CW'(LAT_FMUL);
      U_FDIV:  lat = CW'(LAT_FDIV);
      default: lat = CW'(LAT_ALU);
    endcase
  end

  always_comb begin
    fp_dst   = dec_dst[AW-1];
    is_div   = (dec_unit == U_FDIV);
    wb_slot  = RW'(lat) + RW'(WB_OFF);
    raw_hit  = (dec_src1_en && busy[dec_src1]) || (dec_src2_en && busy[dec_src2]);
    waw_hit  = dec_dst_en && busy[dec_dst];
    div_hit  = is_div && !div_free;
    port_hit = dec_dst_en && fp_dst && slot_taken;
    hold     = raw_hit || waw_hit || div_hit || port_hit;
    stall    = dec_valid && hold;
    issue    = dec_valid && !hold;
    set_en    = issue && dec_dst_en && (dec_dst != '0) && (lat != '0);
    book      = issue && dec_dst_en && fp_dst;
    div_start = issue && is_div;
  end

  hzu_busy_table #(.NREG(NREG), .CW(CW)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_idx (dec_dst),
    .set_cnt (lat),
    .busy    (busy)
  );

  hzu_div_gate #(.DIV_II(DIV_II)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .free  (div_free)
  );

  hzu_wb_reserve #(.DEPTH(DEPTH)) u_wbres (
    .clk   (clk),
    .rst_n (rst_n),
    .book  (book),
    .slot  (wb_slot),
    .taken (slot_taken)
  );

endmodule

// File: rtl/hzu_issue_chk.sv
module hzu_issue_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic [2:0]    dec_unit,
  input logic          dec_dst_en,
  input logic [AW-1:0] dec_dst,
  input logic          dec_src1_en,
  input logic [AW-1:0] dec_src1,
  input logic          dec_src2_en,
  input logic          stall,
  input logic          issue
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && !issue));

  p_valid_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (stall != issue));

  p_load_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_unit == 3'd1 && dec_dst_en && dec_dst != '0)
      |=> !(issue && dec_src1_en && dec_src1 == $past(dec_dst)));

  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_unit == 3'd4) |=> !(issue && dec_unit == 3'd4));

  p_waw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_unit == 3'd2 && dec_dst_en && dec_dst != '0)
      |=> !(issue && dec_dst_en && dec_dst == $past(dec_dst)));

  p_zero_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_unit == 3'd0 && dec_src1_en && dec_src1 == '0
      && !dec_src2_en && !dec_dst_en) |-> issue);

endmodule

bind hzu_issue_ctl hzu_issue_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid   (dec_valid),
  .dec_unit    (dec_unit),
  .dec_dst_en  (dec_dst_en),
  .dec_dst     (dec_dst),
  .dec_src1_en (dec_src1_en),
  .dec_src1    (dec_src1),
  .dec_src2_en (dec_src2_en),
  .stall       (stall),
  .issue       (issue)
);

// File: tb/tb_hzu_issue_ctl.sv
`timescale 1ns/1ps
module tb_hzu_issue_ctl;
  localparam int NREG = 64;
  localparam int AW   = 6;
  localparam realtime TCK = 8.0;

  logic          clk, rst_n;
  logic          dec_valid, dec_dst_en, dec_src1_en, dec_src2_en;
  logic [2:0]    dec_unit;
  logic [AW-1:0] dec_dst, dec_src1, dec_src2;
  logic          stall, issue;

  int checks = 0;
  int fails  = 0;
  bit last_issue;

  // requirement model state
  int          cnt_m [NREG];
  int          div_m;
  logic [63:0] res_m;

  hzu_issue_ctl dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_dst_en(dec_dst_en), .dec_dst(dec_dst),
    .dec_src1_en(dec_src1_en), .dec_src1(dec_src1),
    .dec_src2_en(dec_src2_en), .dec_src2(dec_src2),
    .stall(stall), .issue(issue)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  function automatic int lat_f(logic [2:0] u);
    case (u)
      3'd1: return 1;
      3'd2: return 3;
      3'd3: return 6;
      3'd4: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_hold();
    bit h = 0;
    if (dec_src1_en && cnt_m[dec_src1] > 0) h = 1;
    if (dec_src2_en && cnt_m[dec_src2] > 0) h = 1;
    if (dec_dst_en && cnt_m[dec_dst] > 0) h = 1;
    if (dec_unit == 3'd4 && div_m > 0) h = 1;
    if (dec_dst_en && dec_dst[AW-1] && res_m[lat_f(dec_unit) + 3]) h = 1;
    return h;
  endfunction

  task automatic model_update(input bit iss);
    int l;
    for (int r = 0; r < NREG; r++) if (cnt_m[r] > 0) cnt_m[r]--;
    if (div_m > 0) div_m--;
    res_m = res_m >> 1;
    if (iss) begin
      l = lat_f(dec_unit);
      if (dec_dst_en && dec_dst != 0 && l > 0) cnt_m[dec_dst] = l;
      if (dec_unit == 3'd4) div_m = 24;
      if (dec_dst_en && dec_dst[AW-1]) res_m[l + 2] = 1'b1;
    end
  endtask

  task automatic drive(input bit v, input logic [2:0] u, input bit de, input int d,
                       input bit s1e, input int s1, input bit s2e, input int s2);
    dec_valid = v; dec_unit = u; dec_dst_en = de; dec_dst = AW'(d);
    dec_src1_en = s1e; dec_src1 = AW'(s1); dec_src2_en = s2e; dec_src2 = AW'(s2);
  endtask

  // called just after a negedge with inputs applied
  task automatic step(input string tag);
    bit es, ei;
    #1;
    ei = dec_valid && !model_hold();
    es = dec_valid && !ei;
    checks++;
    if (stall !== es || issue !== ei) begin
      fails++;
      $display("FAIL %s: stall=%b issue=%b expected stall=%b issue=%b", tag, stall, issue, es, ei);
    end
    last_issue = issue;
    model_update(ei);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 3'd0, 0, 0, 0, 0, 0, 0);
      step("R1 idle");
    end
  endtask

  task automatic wait_issue(input string tag, input int exp_n);
    int n = 0;
    for (int i = 0; i < 60; i++) begin
      step(tag);
      if (last_issue) break;
      n++;
    end
    checks++;
    if (n != exp_n) begin
      fails++;
      $display("FAIL %s: stall cycles actual=%0d expected=%0d", tag, n, exp_n);
    end
  endtask

  function automatic int pick_reg();
    int r = int'($urandom % 8);
    return (r < 4) ? r : 32 + (r - 4);
  endfunction

  initial begin
    #(TCK * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < NREG; r++) cnt_m[r] = 0;
    div_m = 0; res_m = '0;
    rst_n = 1'b0;
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: clean state after reset
    idle(1);
    drive(1, 3'd3, 1, 40, 1, 33, 1, 34);
    wait_issue("R9 reset clear", 0);
    idle(30);

    // R2: forwarding latencies
    drive(1, 3'd1, 1, 5, 0, 0, 0, 0); step("R2 load");
    drive(1, 3'd0, 1, 6, 1, 5, 0, 0); wait_issue("R2 load-use", 1);
    idle(30);
    drive(1, 3'd2, 1, 33, 0, 0, 0, 0); step("R2 fadd");
    drive(1, 3'd2, 1, 34, 1, 33, 0, 0); wait_issue("R2 fadd-use", 3);
    idle(30);
    drive(1, 3'd3, 1, 35, 0, 0, 0, 0); step("R2 fmul");
    drive(1, 3'd2, 1, 36, 0, 0, 1, 35); wait_issue("R2 fmul-use", 6);
    idle(30);
    drive(1, 3'd0, 1, 6, 0, 0, 0, 0); step("R2 alu");
    drive(1, 3'd0, 1, 7, 1, 6, 0, 0); wait_issue("R2 alu-use", 0);
    idle(30);

    // R3: divider reissue interval
    drive(1, 3'd4, 1, 37, 0, 0, 0, 0); step("R3 div");
    drive(1, 3'd4, 1, 38, 1, 39, 1, 40); wait_issue("R3 div-div", 24);
    idle(30);

    // R4: WAW waits in decode
    drive(1, 3'd3, 1, 41, 0, 0, 0, 0); step("R4 fmul");
    drive(1, 3'd2, 1, 41, 0, 0, 0, 0); wait_issue("R4 waw", 6);
    idle(30);

    // R5: register 0 never pending
    drive(1, 3'd1, 1, 0, 0, 0, 0, 0); step("R5 load r0");
    drive(1, 3'd0, 1, 8, 1, 0, 0, 0); wait_issue("R5 read r0", 0);
    idle(30);

    // R6: write-port collision
    drive(1, 3'd3, 1, 42, 0, 0, 0, 0); step("R6 fmul");
    idle(2);
    drive(1, 3'd2, 1, 43, 0, 0, 0, 0); wait_issue("R6 port", 1);
    idle(30);

    // R7: a stalled divide leaves no trace
    drive(1, 3'd4, 1, 44, 0, 0, 0, 0); step("R7 div");
    for (int i = 0; i < 3; i++) begin
      drive(1, 3'd4, 1, 45, 0, 0, 0, 0); step("R7 stalled div");
    end
    drive(1, 3'd2, 1, 46, 1, 45, 0, 0); wait_issue("R7 no trace", 0);
    idle(30);

    // R8: independent work passes a long producer
    drive(1, 3'd3, 1, 47, 0, 0, 0, 0); step("R8 fmul");
    drive(1, 3'd0, 1, 7, 1, 8, 0, 0); wait_issue("R8 independent", 0);
    idle(30);

    // random mix, all requirements against the model
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 5) != 0, 3'($urandom % 8), ($urandom % 4) != 0, pick_reg(),
            $urandom % 2, pick_reg(), $urandom % 2, pick_reg());
      step("R1/R2/R3/R4/R6/R7 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule